// File: doc/BRIEF.md
# Bidirectional GPIO Port with Latch Readback

An 8-bit general-purpose I/O port that a processor reaches through a small register bus. Three registers each sit at their own address. A direction register picks, pin by pin, whether the pad drives or floats. An output latch holds the value that driven pins carry. A pin-read address returns the level on each pad.

Both the pin-read address and the latch address write into the same output latch. The two reads differ. The latch address returns the stored latch value. The pin-read address returns the pad levels after a two-flop synchronizer. Because of this, a read-modify-write through the latch address stays correct when a pin is set as an input or is pulled by an outside load.

A mode input gives the pads to an external parallel slave port. While it is high, every output enable is held off. The registers still accept writes and still answer reads.

Top module: `gpio_port`

## Requirements
- R1: After reset the direction register is all ones, the output latch is zero, every pad output enable is low, and read data is zero.
- R2: When direction bit i is 0 and slave mode is low, pad_oe[i] is high. When direction bit i is 1, pad_oe[i] is low. pad_out always shows the output latch.
- R3: A bus write to address 0 (pin-read address) or address 1 (latch address) loads the output latch with the write data. The new value appears on pad_out in the cycle after the write strobe.
- R4: A bus write to address 2 loads the direction register. Writing 0xCF makes bits 3:0 and 7:6 inputs and bits 5:4 outputs, so pad_oe becomes 0x30.
- R5: A read of address 1 returns the output latch value, whatever the pad levels are.
- R6: A read of address 0 returns the pad levels through a two-stage synchronizer. A pad change made just after a clock edge is seen by a read strobed on the third edge after that change, and is not seen by a read strobed on the second edge.
- R7: A read of address 2 returns the direction register.
- R8: Read data is registered. It is valid in the cycle after the read strobe and holds its value while no read is strobed. A read of address 3 returns zero.
- R9: While slave_mode is high, all pad output enables are low, yet writes to the latch and direction registers still take effect and can be read back.
- R10: A write to address 3 changes neither the latch nor the direction register.
- R11: When a read and a write to the latch address happen in the same cycle, the read returns the latch value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register address: 0 pin read, 1 latch, 2 direction, 3 unmapped |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| slave_mode | input | 1 | High hands the pads to the parallel slave port and forces the enables off |
| pin_in | input | 8 | Pad input levels (asynchronous) |
| pad_oe | output | 8 | Per-pin output enable for the tri-state pads |
| pad_out | output | 8 | Per-pin output value for the pads |

## Verification
The hardest case to reach from the ports is the synchronizer delay on pin reads. To set it up, the bench changes pin_in right after a clock edge. It then strobes one read on the second edge after the change, which must return the old level, and a second read on the third edge, which must return the new level. The same-cycle read and write of the latch is a second edge case that is hard to reach: the bench raises both strobes in one cycle and checks that the old value is returned before the new one.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_PIN  = 2'd0,
        SEL_LAT  = 2'd1,
        SEL_DIR  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_in;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_comb begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_out = chain_q[LAST];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_port_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  reg_sel_e         sel,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] lat_q
);
    typedef struct packed {
        logic [WIDTH-1:0] dir;
        logic [WIDTH-1:0] lat;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (sel)
                SEL_PIN, SEL_LAT: st_d.lat = wdata;
                SEL_DIR:          st_d.dir = wdata;
                default:          st_d     = st_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.dir <= '1;
            st_q.lat <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dir_q = st_q.dir;
    assign lat_q = st_q.lat;

    // R3
    lat_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (sel == SEL_PIN || sel == SEL_LAT)) |=> (lat_q == $past(wdata)));

    // R4
    dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_DIR) |=> (dir_q == $past(wdata)));

    // R10
    none_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en || sel == SEL_NONE) |=> ($stable(dir_q) && $stable(lat_q)));
endmodule

// File: rtl/gpio_rdport.sv
module gpio_rdport
    import gpio_port_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  reg_sel_e         sel,
    input  logic [WIDTH-1:0] pin_sync,
    input  logic [WIDTH-1:0] lat,
    input  logic [WIDTH-1:0] dir,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] rdata_d, rdata_q;

    always_comb begin
        rdata_d = rdata_q;
        if (rd_en) begin
            case (sel)
                SEL_PIN: rdata_d = pin_sync;
                SEL_LAT: rdata_d = lat;
                SEL_DIR: rdata_d = dir;
                default: rdata_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign rdata = rdata_q;

    // R5
    rd_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel == SEL_LAT) |=> (rdata == $past(lat)));

    // R6
    rd_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel == SEL_PIN) |=> (rdata == $past(pin_sync)));

    // R7
    rd_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel == SEL_DIR) |=> (rdata == $past(dir)));

    // R8
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

    // R8
    rd_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel == SEL_NONE) |=> (rdata == '0));
endmodule

// File: rtl/gpio_padctl.sv
module gpio_padctl #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] dir,
    input  logic [WIDTH-1:0] lat,
    input  logic             slave_mode,
    output logic [WIDTH-1:0] oe,
    output logic [WIDTH-1:0] dout
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        always_comb begin
            oe[i]   = !dir[i] && !slave_mode;
            dout[i] = lat[i];
        end
    end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic              slave_mode,
    input  logic [WIDTH-1:0]  pin_in,
    output logic [WIDTH-1:0]  pad_oe,
    output logic [WIDTH-1:0]  pad_out
);
    reg_sel_e         sel;
    logic [WIDTH-1:0] dir_q, lat_q, pin_sync;

    assign sel = reg_sel_e'(bus_addr);

    gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(pin_in), .sync_out(pin_sync)
    );

    gpio_regs #(.WIDTH(WIDTH)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .sel(sel),
        .wdata(bus_wdata), .dir_q(dir_q), .lat_q(lat_q)
    );

    gpio_rdport #(.WIDTH(WIDTH)) u_rd (
        .clk(clk), .rst_n(rst_n), .rd_en(bus_rd), .sel(sel),
        .pin_sync(pin_sync), .lat(lat_q), .dir(dir_q), .rdata(bus_rdata)
    );

    gpio_padctl #(.WIDTH(WIDTH)) u_pad (
        .dir(dir_q), .lat(lat_q), .slave_mode(slave_mode),
        .oe(pad_oe), .dout(pad_out)
    );

    // R9
    slave_oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slave_mode |-> (pad_oe == '0));

    // R2
    input_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & dir_q) == '0);

    // R3
    out_follows_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pad_out == lat_q);
endmodule

// File: tb/sim_gpio_port.sv
module sim_gpio_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       slave_mode = 1'b0;
    logic [7:0] pin_in = '0;
    logic [7:0] pad_oe, pad_out;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    gpio_port u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .slave_mode(slave_mode), .pin_in(pin_in), .pad_oe(pad_oe), .pad_out(pad_out)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    initial begin
        #(8 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=00 expected=01");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] r;
        logic [7:0] held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 oe", pad_oe, 8'h00);
        check("R1 out", pad_out, 8'h00);
        check("R1 rdata", bus_rdata, 8'h00);
        rd(2'd2, r); check("R1 dir", r, 8'hFF);
        rd(2'd1, r); check("R1 lat", r, 8'h00);

        // R4 the 0xCF direction pattern
        wr(2'd2, 8'hCF);
        check("R4 oe for CF", pad_oe, 8'h30);
        rd(2'd2, r); check("R7 dir CF", r, 8'hCF);

        // R3 latch sweep through both write addresses
        for (int v = 0; v < 256; v++) begin
            wr((v % 2 == 0) ? 2'd0 : 2'd1, 8'(v));
            check("R3 pad_out", pad_out, 8'(v));
            check("R2 oe with CF", pad_oe, 8'h30);
        end

        // R2 / R7 direction sweep
        for (int d = 0; d < 256; d++) begin
            wr(2'd2, 8'(d));
            check("R2 oe", pad_oe, ~8'(d));
            rd(2'd2, r); check("R7 dir", r, 8'(d));
        end

        // R5 latch read ignores pads
        wr(2'd2, 8'hFF);
        wr(2'd1, 8'hA5);
        pin_in = 8'h5A;
        repeat (3) @(negedge clk);
        rd(2'd1, r); check("R5 lat vs pins", r, 8'hA5);

        // R6 pin sweep with two-stage delay
        for (int p = 0; p < 256; p++) begin
            pin_in = 8'(p);
            @(negedge clk); @(negedge clk);
            rd(2'd0, r); check("R6 pin", r, 8'(p));
        end

        // R6 latency: strobe on 2nd edge is old, on 3rd edge is new
        pin_in = 8'hC3;
        repeat (3) @(negedge clk);
        pin_in = 8'h3C;
        @(negedge clk);
        rd(2'd0, r); check("R6 old at 2nd edge", r, 8'hC3);
        rd(2'd0, r); check("R6 new at 3rd edge", r, 8'h3C);

        // R8 hold and unmapped read
        rd(2'd1, r); held = r;
        wr(2'd1, 8'h11);
        repeat (3) @(negedge clk);
        check("R8 hold", bus_rdata, held);
        rd(2'd3, r); check("R8 unmapped", r, 8'h00);

        // R10 write to unmapped address
        wr(2'd2, 8'h0F);
        wr(2'd1, 8'h66);
        wr(2'd3, 8'h77);
        rd(2'd1, r); check("R10 lat kept", r, 8'h66);
        rd(2'd2, r); check("R10 dir kept", r, 8'h0F);

        // R9 slave mode
        wr(2'd2, 8'h00);
        slave_mode = 1'b1;
        #1 check("R9 oe off", pad_oe, 8'h00);
        @(negedge clk);
        wr(2'd1, 8'h99);
        wr(2'd2, 8'h0F);
        check("R9 oe still off", pad_oe, 8'h00);
        check("R9 out", pad_out, 8'h99);
        rd(2'd1, r); check("R9 lat write", r, 8'h99);
        rd(2'd2, r); check("R9 dir write", r, 8'h0F);
        slave_mode = 1'b0;
        #1 check("R9 oe back", pad_oe, 8'hF0);
        @(negedge clk);

        // R11 read and write of latch in one cycle
        bus_addr = 2'd1; bus_wdata = 8'h42; bus_wr = 1'b1; bus_rd = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        check("R11 old value", bus_rdata, 8'h99);
        rd(2'd1, r); check("R11 new value", r, 8'h42);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule